// File: doc/BRIEF.md
# Bus Cycle Sequencer with Hold Handshake

This block paces the processor side of a shared local bus through its clock states: idle (TI), address (T1), T2, data (T3), wait (TW) and the closing T4. A user issues a bus cycle on a valid/ready request port that carries a cycle-type code. While the cycle runs, the code is presented on a three-bit status output, and it also appears one state early, during the T4 before the cycle. Slow targets stretch a cycle by holding `ready` low. A `done` pulse marks the final clock of every cycle.

A second bus master can ask for the bus by raising `hold`. The grant is only given halfway through a T4 or an idle state. In the same half-clock that `hlda` rises, `bus_en` drops, so that the address, data and control drivers float. Once `hold` is seen low again, `hlda` falls, but the bus stays floated until the sequencer actually has a new cycle to run. The request port follows valid/ready rules. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the user must hold `req_valid` and `req_type` steady. The `hold` input is treated as synchronous by default. Setting the `SYNC_STAGES` parameter above zero inserts a flop chain in front of it, for systems that cannot meet its setup time.

Top module: `bus_seq`

## Requirements
- R1: While reset is asserted and after its release with no request, the sequencer is idle: `status` = 3'b111, `hlda` = 0, `bus_en` = 1, `done` = 0, `req_ready` = 1.
- R2: A request accepted on a rising edge starts T1 on that edge, followed by T2 and T3 on the next edges. With `ready` high, T4 follows T3, so `done` is high in the fourth clock after acceptance.
- R3: `status` carries the stored cycle type during T1 and T2. During T4 and TI it carries `req_type` while a request is being accepted and 3'b111 otherwise.
- R4: In T3 and TW, `status` is 3'b111 whenever `ready` is high and keeps the cycle type while `ready` is low.
- R5: `ready` low on the rising edge that ends T3 or TW enters (or stays in) TW. `ready` high on that edge enters T4.
- R6: `done` is high exactly for the single clock spent in T4.
- R7: `req_ready` is high only in TI or T4, and only when no hold was sampled at the start of that state and `hlda` is low.
- R8: `hlda` rises only on a falling clock edge inside a T4 or TI state whose opening rising edge sampled `hold` high.
- R9: `bus_en` falls on the same falling edge on which `hlda` rises, and is low whenever `hlda` is high.
- R10: With `hlda` high, a rising edge that samples `hold` low makes `hlda` fall on the following falling edge. The sequencer stays in TI.
- R11: After a grant, `bus_en` stays low until a request is accepted, and it rises at the start of that request's T1.
- R12: While `hlda` is high, `status` is 3'b111 and `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; states change on rising edges, hold grant and release on falling edges |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A bus cycle is requested |
| req_ready | output | 1 | The sequencer can take a request on this edge |
| req_type | input | TYPE_W | Cycle-type code of the request (3'b111 is the passive code) |
| ready | input | 1 | Target ready; low in T3/TW inserts wait states |
| hold | input | 1 | Another master requests the bus (active high) |
| hlda | output | 1 | Hold acknowledge |
| bus_en | output | 1 | High: drive address, data and control lines; low: float them |
| status | output | TYPE_W | Cycle-type status, 3'b111 when passive |
| done | output | 1 | High during the last clock (T4) of each bus cycle |

## Verification
Some rules are checked on every clock by the assertions:
- `done` never lasts two clocks.
- `hlda` only rises out of T4 or TI, and `bus_en` is low while it is high.
- `status` is passive and `req_ready` is low while the bus is granted.
- T1 and T2 always advance, and a low `ready` keeps or enters a wait state.
- `bus_en` only returns at T1.

Only the bench's scenarios can show the exact half-clock on which a grant appears and disappears after `hold` changes. The same is true of the status lookahead during T4, of the back-to-back cycles, and of the bus staying floated through idle clocks after `hold` drops until the next request.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    ST_TI = 3'd0,
    ST_T1 = 3'd1,
    ST_T2 = 3'd2,
    ST_T3 = 3'd3,
    ST_TW = 3'd4,
    ST_T4 = 3'd5
  } bus_st_e;
endpackage

// File: rtl/bus_seq_sync.sv
module bus_seq_sync #(
  parameter int STAGES = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_chain
      logic [STAGES:0] sh;
      assign sh[0] = d;
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh[i+1] <= 1'b0;
          else        sh[i+1] <= sh[i];
        end
      end
      assign q = sh[STAGES];
    end
  endgenerate
endmodule

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
#(
  parameter int TYPE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [TYPE_W-1:0] req_type,
  input  logic              ready,
  input  logic              take,
  input  logic              hlda,
  output logic              req_ready,
  output logic              accept,
  output logic              win,
  output logic [TYPE_W-1:0] status,
  output logic              done,
  output bus_st_e           st
);
  localparam logic [TYPE_W-1:0] PASSIVE = '1;

  bus_st_e           nxt;
  logic [TYPE_W-1:0] type_q;

  assign req_ready = ((st == ST_TI) || (st == ST_T4)) && !take && !hlda;
  assign accept    = req_ready && req_valid;
  assign done      = (st == ST_T4);

  always_comb begin
    nxt = st;
    unique case (st)
      ST_TI:   nxt = accept ? ST_T1 : ST_TI;
      ST_T1:   nxt = ST_T2;
      ST_T2:   nxt = ST_T3;
      ST_T3:   nxt = ready ? ST_T4 : ST_TW;
      ST_TW:   nxt = ready ? ST_T4 : ST_TW;
      ST_T4:   nxt = accept ? ST_T1 : ST_TI;
      default: nxt = ST_TI;
    endcase
  end

  assign win = (nxt == ST_T4) || (nxt == ST_TI);

  always_comb begin
    status = PASSIVE;
    unique case (st)
      ST_T1, ST_T2: status = type_q;
      ST_T3, ST_TW: status = ready ? PASSIVE : type_q;
      ST_T4, ST_TI: status = accept ? req_type : PASSIVE;
      default:      status = PASSIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_TI;
      type_q <= PASSIVE;
    end else begin
      st <= nxt;
      if (accept) type_q <= req_type;
    end
  end
endmodule

// File: rtl/bus_seq_hold.sv
module bus_seq_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_s,
  input  logic win,
  input  logic accept,
  output logic take,
  output logic hlda,
  output logic bus_en
);
  logic parked_q;

  // hold is looked at on the rising edge that opens T4 or TI
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) take <= 1'b0;
    else        take <= win && hold_s;
  end

  // grant and release happen mid-state
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) hlda <= 1'b0;
    else        hlda <= take;
  end

  // bus stays floated after release until a new cycle begins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      parked_q <= 1'b0;
    else if (accept) parked_q <= 1'b0;
    else if (hlda)   parked_q <= 1'b1;
  end

  assign bus_en = !hlda && !parked_q;
endmodule

// File: rtl/bus_seq.sv
module bus_seq
  import bus_seq_pkg::*;
#(
  parameter int TYPE_W      = 3,
  parameter int SYNC_STAGES = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [TYPE_W-1:0] req_type,
  input  logic              ready,
  input  logic              hold,
  output logic              hlda,
  output logic              bus_en,
  output logic [TYPE_W-1:0] status,
  output logic              done
);
  logic    hold_s;
  logic    take;
  logic    accept;
  logic    win;
  bus_st_e st_q;

  bus_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(hold), .q(hold_s)
  );

  bus_seq_fsm #(.TYPE_W(TYPE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .ready(ready), .take(take), .hlda(hlda), .req_ready(req_ready),
    .accept(accept), .win(win), .status(status), .done(done), .st(st_q)
  );

  bus_seq_hold u_hold (
    .clk(clk), .rst_n(rst_n), .hold_s(hold_s), .win(win), .accept(accept),
    .take(take), .hlda(hlda), .bus_en(bus_en)
  );
endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk
  import bus_seq_pkg::*;
#(
  parameter int TYPE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              hlda,
  input logic              bus_en,
  input logic [TYPE_W-1:0] status,
  input logic              done,
  input logic              req_ready,
  input bus_st_e           st
);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R12
  passive_in_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (status == '1) && !req_ready);
  // R9
  float_in_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> !bus_en);
  // R8
  grant_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> (st == ST_T4) || (st == ST_TI));
  // R2
  t1_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_T1) |=> (st == ST_T2));
  // R2
  t2_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_T2) |=> (st == ST_T3));
  // R5
  wait_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_T3) || (st == ST_TW)) && !ready |=> (st == ST_TW));
  // R11
  drive_at_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_en) |-> (st == ST_T1));
endmodule

bind bus_seq bus_seq_chk #(.TYPE_W(TYPE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .hlda(hlda), .bus_en(bus_en),
  .status(status), .done(done), .req_ready(req_ready), .st(st_q)
);

// File: tb/bus_seq_test.sv
module bus_seq_test;
  localparam int S_TI = 0, S_T1 = 1, S_T2 = 2, S_T3 = 3, S_TW = 4, S_T4 = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_type = 3'b000;
  logic       ready = 1'b1;
  logic       hold = 1'b0;
  logic       req_ready, hlda, bus_en, done;
  logic [2:0] status;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bus_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .ready(ready), .hold(hold), .hlda(hlda),
    .bus_en(bus_en), .status(status), .done(done)
  );

  // behavioural reference
  int       m_st = S_TI;
  bit       m_take = 0, m_hlda = 0, m_parked = 0, m_acc = 0;
  bit [2:0] m_type = 3'b111;
  int       q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = S_TI; m_take = 0; m_parked = 0; m_type = 3'b111; m_acc = 0;
    end else begin
      m_acc = (m_st == S_TI || m_st == S_T4) && req_valid && !m_take && !m_hlda;
      if (m_acc) m_type = req_type;
      if (m_acc) m_parked = 0; else if (m_hlda) m_parked = 1;
      case (m_st)
        S_TI: m_st = m_acc ? S_T1 : S_TI;
        S_T1: m_st = S_T2;
        S_T2: m_st = S_T3;
        S_T3: m_st = ready ? S_T4 : S_TW;
        S_TW: m_st = ready ? S_T4 : S_TW;
        default: m_st = m_acc ? S_T1 : S_TI;
      endcase
      m_take = (m_st == S_T4 || m_st == S_TI) && hold;
    end
  end

  always @(negedge clk) m_hlda = rst_n ? m_take : 1'b0;

  // request driver honouring valid/ready
  always @(posedge clk) begin
    #2;
    if (m_acc && q.size() > 0) void'(q.pop_front());
    m_acc = 0;
    req_valid = (q.size() > 0);
    req_type  = (q.size() > 0) ? 3'(q[0]) : 3'b000;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic bit [2:0] exp_status();
    bit acc_now = (m_st == S_TI || m_st == S_T4) && req_valid && !m_take && !m_hlda;
    case (m_st)
      S_T1, S_T2: return m_type;
      S_T3, S_TW: return ready ? 3'b111 : m_type;
      default:    return acc_now ? req_type : 3'b111;
    endcase
  endfunction

  // compare after each rising edge and after each falling edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !finished) begin
      chk(status == exp_status(), "R3 R4 R12 status", status, exp_status());
      chk(done == (m_st == S_T4), "R2 R5 R6 done", done, (m_st == S_T4));
      chk(req_ready == ((m_st == S_TI || m_st == S_T4) && !m_take && !m_hlda),
          "R7 R12 req_ready", req_ready,
          ((m_st == S_TI || m_st == S_T4) && !m_take && !m_hlda));
      chk(hlda == m_hlda, "R8 R10 hlda", hlda, m_hlda);
      chk(bus_en == (!m_hlda && !m_parked), "R9 R11 bus_en", bus_en, (!m_hlda && !m_parked));
    end
  end

  always @(negedge clk) begin
    #5;
    if (rst_n && !finished) begin
      chk(hlda == m_hlda, "R8 R10 hlda mid-state", hlda, m_hlda);
      chk(bus_en == (!m_hlda && !m_parked), "R9 R11 bus_en mid-state", bus_en,
          (!m_hlda && !m_parked));
    end
  end

  task automatic report();
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #(20 * 50000);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    edges(3);
    // R1 reset state
    chk(status == 3'b111, "R1 status", status, 7);
    chk(hlda == 1'b0, "R1 hlda", hlda, 0);
    chk(bus_en == 1'b1, "R1 bus_en", bus_en, 1);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    rst_n = 1'b1;
    edges(3);
    // R2 R3 single cycle, then back-to-back
    q.push_back(5);
    edges(8);
    q.push_back(1); q.push_back(6); q.push_back(2);
    edges(16);
    // R4 R5 wait states
    q.push_back(4);
    edges(1);
    ready = 1'b0;
    edges(5);
    ready = 1'b1;
    edges(6);
    // R8 R9 hold arriving mid-cycle, request queued behind it
    q.push_back(3); q.push_back(0);
    edges(2);
    hold = 1'b1;
    edges(7);
    hold = 1'b0;
    edges(12);
    // R10 R11 hold in idle, bus stays floated after release
    hold = 1'b1;
    edges(5);
    hold = 1'b0;
    edges(5);
    q.push_back(6);
    edges(8);
    // R12 hold pulse while a request waits in idle
    hold = 1'b1;
    edges(2);
    q.push_back(2);
    edges(4);
    hold = 1'b0;
    edges(10);
    report();
  end
endmodule